// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a serial bit stream into a parallel word and holds that word steady while the next one arrives. Bits enter one per rising edge of a shift clock. A separate storage clock copies the whole shift chain into a storage register in a single step. The parallel outputs show only the storage register, so the receiving logic never sees a word that is half shifted.

An active-low asynchronous clear empties the shift chain and leaves the storage register alone. A bus-off input puts the parallel outputs into high impedance. A plain copy of the stored word and a drive-enable flag are also brought out, so that checks inside the chip do not depend on tri-state resolution. The last shift stage drives a cascade output at all times. The cascade output can feed the serial input of another instance, which builds a longer register from several instances.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising edge of `shift_clk` while `shift_clr_n` is high, `data_in` goes into stage 0 of the shift chain, and stage i takes the old value of stage i-1, for i from 1 to WIDTH-1.
- R2: While `shift_clr_n` is low, every shift stage is 0, with no clock edge needed. Rising `shift_clk` edges during that time leave the stages at 0.
- R3: The clear has no effect on the storage register. `par_data` and the driven `par_out` keep their value through a clear.
- R4: On each rising edge of `store_clk`, the storage register takes the whole shift chain at once, in the same bit order: stage i goes to `par_data[i]`. Shift edges without a storage edge leave `par_data` unchanged.
- R5: When `bus_off` is 1, `par_drv` is 0 and all `par_out` bits are high impedance. When `bus_off` is 0, `par_drv` is 1 and `par_out` equals `par_data`. `par_data` always shows the storage register.
- R6: `chain_out` always equals shift stage WIDTH-1. It ignores `bus_off` and does not pass through the storage register.
- R7: When `shift_clk` and `store_clk` rise together, the storage register takes the chain contents from before that edge, so it lags the chain by one pulse.
- R8: With two instances chained from `chain_out` to `data_in` and sharing their clocks, 2*WIDTH shift pulses load a 2*WIDTH-bit word. The first bit in ends at stage WIDTH-1 of the downstream instance. One shared storage edge then transfers both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift chain clock, rising edge |
| shift_clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| data_in | input | 1 | Serial data into stage 0 |
| store_clk | input | 1 | Storage register clock, rising edge |
| bus_off | input | 1 | 1 puts par_out into high impedance |
| par_out | output | WIDTH | Tri-state parallel output of the storage register |
| par_data | output | WIDTH | Plain copy of the storage register |
| par_drv | output | 1 | 1 while par_out is driven |
| chain_out | output | 1 | Last shift stage, for cascading |

## Verification
Shift stages and `chain_out` change on the rising `shift_clk` edge that causes them. The storage register changes on the rising `store_clk` edge. The clear acts at once, without any edge. `par_out` and `par_drv` follow `bus_off` and the storage register combinationally. The bench raises a clock for half a period and then lowers it. It samples every output after the falling half of the pulse and changes inputs only while both clocks are low, so each check reads the state that the most recent edge left. A queue model of both chained instances is updated before each pulse from its pre-edge values. This gives the tied-clock case its one-pulse lag without copying the design's logic.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    // Drive state of the parallel output stage
    typedef enum logic {
        DRIVE_OFF = 1'b0,
        DRIVE_ON  = 1'b1
    } drive_e;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stage_o,
    output logic             tail_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage;
    } chain_s;

    chain_s cur_q;
    chain_s nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.stage = {cur_q.stage[WIDTH-2:0], din};
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stage_o = cur_q.stage;
    assign tail_o  = cur_q.stage[WIDTH-1];

    // R1: new bit enters stage 0, older bits move one stage up
    a_r1_shift_step: assert property (@(posedge clk) disable iff (!clr_n)
        $past(clr_n) |-> (stage_o[0] == $past(din)) &&
                         (stage_o[WIDTH-1:1] == $past(stage_o[WIDTH-2:0])));

    // R2: a held clear keeps every stage at zero across shift edges
    a_r2_clear_holds: assert property (@(posedge clk)
        !clr_n |-> (stage_o == '0));
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] hold_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_s;

    // No reset of its own: starts at zero, changes only on its clock
    hold_s cur_q = '0;
    hold_s nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.word = src_i;
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign hold_o = cur_q.word;

    // Arms the transfer check once a first storage edge has been seen
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
    end

    // R4 / R7: each storage edge captures the source as it stood before that edge
    a_r4_transfer: assert property (@(posedge clk) disable iff (!armed_q)
        hold_o == $past(src_i));
endmodule

// File: rtl/sipo_out_drive.sv
module sipo_out_drive
    import sipo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             bus_off,
    input  logic [WIDTH-1:0] hold_i,
    output logic [WIDTH-1:0] bus_o,
    output logic             en_o
);
    drive_e mode;

    always_comb begin
        mode = bus_off ? DRIVE_OFF : DRIVE_ON;
    end

    assign en_o = (mode == DRIVE_ON);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bus_o[i] = en_o ? hold_i[i] : 1'bz;
    end
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
    parameter int WIDTH = 8
) (
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             data_in,
    input  logic             store_clk,
    input  logic             bus_off,
    output logic [WIDTH-1:0] par_out,
    output logic [WIDTH-1:0] par_data,
    output logic             par_drv,
    output logic             chain_out
);
    logic [WIDTH-1:0] chain_w;
    logic [WIDTH-1:0] hold_w;

    sipo_shift_chain #(.WIDTH(WIDTH)) i_chain (
        .clk     (shift_clk),
        .clr_n   (shift_clr_n),
        .din     (data_in),
        .stage_o (chain_w),
        .tail_o  (chain_out)
    );

    sipo_hold_reg #(.WIDTH(WIDTH)) i_hold (
        .clk    (store_clk),
        .src_i  (chain_w),
        .hold_o (hold_w)
    );

    sipo_out_drive #(.WIDTH(WIDTH)) i_drive (
        .bus_off (bus_off),
        .hold_i  (hold_w),
        .bus_o   (par_out),
        .en_o    (par_drv)
    );

    assign par_data = hold_w;

    // R6: the cascade pin tracks the chain's top stage, fed from the stage below it
    a_r6_cascade_follows: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        $past(shift_clr_n) |-> chain_out == $past(chain_w[WIDTH-2]));
endmodule

// File: tb/test_sipo_latch_reg.sv
module test_sipo_latch_reg;
    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;

    logic         shift_clk = 1'b0;
    logic         store_clk = 1'b0;
    logic         clr_n     = 1'b0;
    logic         din       = 1'b0;
    logic         bus_off   = 1'b1;

    wire [W-1:0]  u_pout;
    logic [W-1:0] u_pdata;
    logic         u_drv;
    logic         u_casc;
    wire [W-1:0]  d_pout;
    logic [W-1:0] d_pdata;
    logic         d_drv;
    logic         d_casc;

    sipo_latch_reg #(.WIDTH(W)) i_sipo_latch_reg (
        .shift_clk (shift_clk), .shift_clr_n (clr_n), .data_in (din),
        .store_clk (store_clk), .bus_off (bus_off), .par_out (u_pout),
        .par_data (u_pdata), .par_drv (u_drv), .chain_out (u_casc)
    );

    sipo_latch_reg #(.WIDTH(W)) i_sipo_latch_reg_dn (
        .shift_clk (shift_clk), .shift_clr_n (clr_n), .data_in (u_casc),
        .store_clk (store_clk), .bus_off (bus_off), .par_out (d_pout),
        .par_data (d_pdata), .par_drv (d_drv), .chain_out (d_casc)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model of both chained instances
    logic [W-1:0] m_su = '0, m_sd = '0, m_hu = '0, m_hd = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic s, input logic l);
        logic [W-1:0] ou, od;
        ou = m_su;
        od = m_sd;
        if (s && clr_n) begin
            m_su = {ou[W-2:0], din};
            m_sd = {od[W-2:0], ou[W-1]};
        end
        if (l) begin
            m_hu = ou;
            m_hd = od;
        end
        #(CLK_PERIOD/2);
        shift_clk = s;
        store_clk = l;
        #(CLK_PERIOD/2);
        shift_clk = 1'b0;
        store_clk = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        #(CLK_PERIOD);
        chk("R2 reset chain_out", u_casc, 0);
        chk("R5 reset par_data", u_pdata, 0);
        chk("R5 reset par_drv off", u_drv, 0);
        clr_n = 1'b1;
        #1;
    endtask

    task automatic t_shift_and_store();
        logic [W-1:0] pat;
        pat = 8'hA5;
        for (int i = 0; i < W; i++) begin
            din = pat[W-1-i];
            pulse(1'b1, 1'b0);
            chk("R1 shift chain_out", u_casc, m_su[W-1]);
            chk("R4 no store edge keeps par_data", u_pdata, 0);
        end
        chk("R6 chain_out is top bit of pattern", u_casc, pat[W-1]);
        pulse(1'b0, 1'b1);
        chk("R4 storage edge loads pattern", u_pdata, pat);
        bus_off = 1'b0;
        #1;
        chk("R5 driven par_out equals storage", u_pout, pat);
        chk("R5 par_drv on", u_drv, 1);
    endtask

    task automatic t_bus_off();
        logic c;
        c = u_casc;
        bus_off = 1'b1;
        #1;
        chk("R5 bus_off clears par_drv", u_drv, 0);
        chk("R6 chain_out ignores bus_off", u_casc, c);
        chk("R5 par_data unaffected by bus_off", u_pdata, m_hu);
        din = 1'b0;
        pulse(1'b1, 1'b0);
        chk("R6 chain_out shifts while bus off", u_casc, m_su[W-1]);
        bus_off = 1'b0;
        #1;
        chk("R5 re-enabled par_out", u_pout, m_hu);
    endtask

    task automatic t_clear_mid();
        din = 1'b1;
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        clr_n = 1'b0;
        m_su = '0;
        m_sd = '0;
        #1;
        chk("R2 clear empties chain at once", u_casc, 0);
        chk("R3 clear keeps par_data", u_pdata, m_hu);
        chk("R3 clear keeps par_out", u_pout, m_hu);
        din = 1'b1;
        pulse(1'b1, 1'b0);
        chk("R2 shift edge under clear ignored", u_casc, 0);
        pulse(1'b0, 1'b1);
        chk("R2 cleared chain stores zero", u_pdata, 0);
        clr_n = 1'b1;
        #1;
    endtask

    task automatic t_tied();
        logic [W-1:0] pat;
        pat = 8'h3C;
        for (int i = 0; i < W; i++) begin
            din = pat[W-1-i];
            pulse(1'b1, 1'b1);
            chk("R7 tied clocks lag one pulse", u_pdata, m_hu);
        end
        chk("R7 tied lag holds pattern shifted down by one", u_pdata, {1'b0, pat[W-1:1]});
        pulse(1'b0, 1'b1);
        chk("R7 extra storage edge catches up", u_pdata, pat);
    endtask

    task automatic t_chain();
        logic [2*W-1:0] word;
        word = 16'hC35A;
        for (int i = 0; i < 2*W; i++) begin
            din = word[2*W-1-i];
            pulse(1'b1, 1'b0);
            chk("R8 chained tail", d_casc, m_sd[W-1]);
        end
        pulse(1'b0, 1'b1);
        chk("R8 upstream half", u_pdata, word[W-1:0]);
        chk("R8 downstream half", d_pdata, word[2*W-1:W]);
        chk("R8 downstream par_out driven", d_pout, word[2*W-1:W]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_shift_and_store();
        t_bus_off();
        t_clear_mid();
        t_tied();
        t_chain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule